// File: doc/BRIEF.md
# Four-Slice Carry Lookahead Generator

This block speeds up carry resolution across a wide adder or ALU made of four arithmetic slices. Each slice reports whether it would create a carry on its own (generate) and whether it would pass an incoming carry through (propagate). Both of these flags are active low. From them and one active-high incoming carry, the block derives the active-high carries into slices 1, 2 and 3 at once, so no carry has to ripple through the slices.

The block also produces a group generate and a group propagate, both active low, that summarise all four slices. A second unit of the same kind can take these at a higher lookahead level. Units at the same level may instead be chained by rippling the carry. The connections stay the same whether the attached slices work on active-high or active-low operands.

The block has no clock, reset or storage. Every output settles from the present inputs alone.

Top module: `cla_gen4`

## Requirements
- R1: Each propagate and generate input counts as asserted when low. The carry input and all carry outputs count as asserted when high. With every status input high and the carry input low, all three carries are low and both group outputs are high.
- R2: `carry_out[0]` (the carry into slice 1) is high when generate 0 is asserted, or when propagate 0 is asserted and `carry_in` is high.
- R3: `carry_out[1]` (the carry into slice 2) is high when any of these holds:
  - generate 1 is asserted;
  - propagate 1 and generate 0 are asserted;
  - propagate 1 and propagate 0 are asserted and `carry_in` is high.
- R4: `carry_out[2]` (the carry into slice 3) is high when any of these holds:
  - generate 2 is asserted;
  - a lower generate (1 or 0) is asserted and every propagate above it, up to and including slice 2, is asserted;
  - `carry_in` is high and propagates 0, 1 and 2 are all asserted.
- R5: `grp_gen_n` is driven low when any of these holds, and it does not depend on `carry_in`:
  - generate 3 is asserted;
  - a lower generate (2, 1 or 0) is asserted and every propagate above it, up to and including slice 3, is asserted.
- R6: `grp_prop_n` is driven low only when all four propagate inputs are low. It does not depend on `carry_in`.
- R7: The outputs depend only on the present inputs. After a prior pattern has been applied, re-applying an input pattern yields the same outputs as before.
- R8: Placed beneath four 4-bit adder slices, the block gives a correct 16-bit sum. The slice carry-ins are `carry_in`, `carry_out[0]`, `carry_out[1]` and `carry_out[2]`. The final carry out equals (not `grp_gen_n`) or (not `grp_prop_n` and `carry_in`). `grp_gen_n` is low exactly when the two operands alone overflow 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prop_n | input | 4 | Per-slice propagate, active low, bit i for slice i |
| gen_n | input | 4 | Per-slice generate, active low, bit i for slice i |
| carry_in | input | 1 | Carry into slice 0, active high |
| carry_out | output | 3 | Bit i is the carry into slice i+1, active high |
| grp_gen_n | output | 1 | Group generate over all four slices, active low |
| grp_prop_n | output | 1 | Group propagate over all four slices, active low |

## Verification
All 512 combinations of the nine inputs are applied in order and compared with a ripple-form reference. This shows whether each carry sees exactly the right generate and propagate terms, and whether the carry input leaks into the group outputs. A seeded random pass and a revisit of an earlier pattern after its opposite confirm that no output depends on past inputs. A 16-bit adder is then built around the block in the bench and driven with random operands and with edge operands such as all-ones plus a carry. These operands tell apart a carry that travels the full length of the adder, a carry that is generated by a slice, and the case with no carry at all.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Summary of a span of slices, active-high meaning internally
  typedef struct packed {
    logic gen;
    logic prop;
  } span_pg_t;
endpackage

// File: rtl/cla_polarity.sv
module cla_polarity #(
  parameter int W = 4
) (
  input  logic [W-1:0] low_true,
  output logic [W-1:0] high_true
);
  for (genvar i = 0; i < W; i++) begin : g_inv
    assign high_true[i] = ~low_true[i];
  end
endmodule

// File: rtl/cla_carry_terms.sv
module cla_carry_terms #(
  parameter int NGRP = 4,
  localparam int NOUT = NGRP - 1
) (
  input  logic [NGRP-1:0] p,
  input  logic [NGRP-1:0] g,
  input  logic            cin,
  output logic [NOUT-1:0] c_next
);
  // Flattened sum of products per output: no term waits on another carry
  for (genvar k = 0; k < NOUT; k++) begin : g_carry
    always_comb begin
      logic acc;
      logic run;
      acc = g[k];
      run = p[k];
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (run & g[j]);
        run = run & p[j];
      end
      c_next[k] = acc | (run & cin);
    end
  end
endmodule

// File: rtl/cla_group_terms.sv
module cla_group_terms
  import cla_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic [NGRP-1:0] p,
  input  logic [NGRP-1:0] g,
  output span_pg_t        span
);
  always_comb begin
    logic acc;
    logic run;
    acc = g[NGRP-1];
    run = p[NGRP-1];
    for (int j = NGRP - 2; j >= 0; j--) begin
      acc = acc | (run & g[j]);
      run = run & p[j];
    end
    span.gen  = acc;
    span.prop = &p;
  end
endmodule

// File: rtl/cla_gen4.sv
module cla_gen4
  import cla_pkg::*;
#(
  parameter int NGRP = 4,
  localparam int NC = NGRP - 1
) (
  input  logic [NGRP-1:0] prop_n,
  input  logic [NGRP-1:0] gen_n,
  input  logic            carry_in,
  output logic [NC-1:0]   carry_out,
  output logic            grp_gen_n,
  output logic            grp_prop_n
);
  logic [NGRP-1:0] p_act;
  logic [NGRP-1:0] g_act;
  span_pg_t        span;

  cla_polarity #(.W(NGRP)) u_pol_p (.low_true(prop_n), .high_true(p_act));
  cla_polarity #(.W(NGRP)) u_pol_g (.low_true(gen_n),  .high_true(g_act));

  cla_carry_terms #(.NGRP(NGRP)) u_carry (
    .p(p_act), .g(g_act), .cin(carry_in), .c_next(carry_out)
  );

  cla_group_terms #(.NGRP(NGRP)) u_group (
    .p(p_act), .g(g_act), .span(span)
  );

  assign grp_gen_n  = ~span.gen;
  assign grp_prop_n = ~span.prop;

  always_comb begin
    if (gen_n == '1 && prop_n == '1 && carry_in == 1'b0)
      AST_IDLE_QUIET: assert (carry_out == '0 && grp_gen_n && grp_prop_n); // R1
    if (gen_n[0] == 1'b0)
      AST_SLICE0_GEN: assert (carry_out[0] == 1'b1); // R2
    if (gen_n[0] == 1'b0 && prop_n[NC:1] == '0)
      AST_GEN0_SPANS: assert (carry_out == '1 && grp_gen_n == 1'b0); // R3
    if (prop_n == '0 && carry_in)
      AST_FULL_PASS: assert (carry_out == '1 && grp_prop_n == 1'b0); // R6
    if (gen_n == '1)
      AST_NO_GEN_NO_GRP: assert (grp_gen_n == 1'b1); // R5
  end

  for (genvar k = 0; k + 1 < NC; k++) begin : g_chk
    always_comb begin
      if (carry_out[k] && prop_n[k+1] == 1'b0)
        AST_CARRY_ADVANCES: assert (carry_out[k+1] == 1'b1); // R4
    end
  end
endmodule

// File: tb/cla_gen4_bench.sv
`timescale 1ns/1ps
module cla_gen4_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] prop_n, gen_n;
  logic       carry_in;
  logic [2:0] carry_out;
  logic       grp_gen_n, grp_prop_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  cla_gen4 u_cla_gen4 (
    .prop_n(prop_n), .gen_n(gen_n), .carry_in(carry_in),
    .carry_out(carry_out), .grp_gen_n(grp_gen_n), .grp_prop_n(grp_prop_n)
  );

  // Ripple-form reference: {gp_n, gg_n, c3, c2, c1}
  function automatic logic [4:0] model(input logic [3:0] pn, input logic [3:0] gn,
                                       input logic ci);
    logic c;
    logic [2:0] co;
    logic gg;
    c = ci;
    for (int i = 0; i < 3; i++) begin
      c = ~gn[i] | (~pn[i] & c);
      co[i] = c;
    end
    gg = 1'b0;
    for (int i = 0; i < 4; i++) gg = ~gn[i] | (~pn[i] & gg);
    return {(pn != 4'b0000), ~gg, co};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] pn, input logic [3:0] gn, input logic ci);
    @(negedge clk);
    prop_n = pn; gen_n = gn; carry_in = ci;
    #1;
  endtask

  task automatic check_all(input logic [3:0] pn, input logic [3:0] gn, input logic ci);
    logic [4:0] e;
    apply(pn, gn, ci);
    e = model(pn, gn, ci);
    chk(carry_out[0] === e[0], "R2", 32'(carry_out[0]), 32'(e[0]));
    chk(carry_out[1] === e[1], "R3", 32'(carry_out[1]), 32'(e[1]));
    chk(carry_out[2] === e[2], "R4", 32'(carry_out[2]), 32'(e[2]));
    chk(grp_gen_n === e[3], "R5", 32'(grp_gen_n), 32'(e[3]));
    chk(grp_prop_n === e[4], "R6", 32'(grp_prop_n), 32'(e[4]));
  endtask

  task automatic add16(input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic [3:0] pn, gn;
    logic [3:0] cc;
    logic [15:0] s;
    logic co;
    logic [16:0] exp;
    for (int k = 0; k < 4; k++) begin
      logic [4:0] t;
      t = {1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]};
      gn[k] = ~(t >= 5'd16);
      pn[k] = ~(t >= 5'd15);
    end
    apply(pn, gn, ci);
    cc = {carry_out, ci};
    for (int k = 0; k < 4; k++) s[4*k +: 4] = a[4*k +: 4] + b[4*k +: 4] + 4'(cc[k]);
    co = ~grp_gen_n | (~grp_prop_n & ci);
    exp = {1'b0, a} + {1'b0, b} + 17'(ci);
    chk({co, s} === exp, "R8 sum", 32'({co, s}), 32'(exp));
    chk(grp_gen_n === ~(({1'b0, a} + {1'b0, b}) >= 17'h10000), "R8 group",
        32'(grp_gen_n), 32'(~(({1'b0, a} + {1'b0, b}) >= 17'h10000)));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    // Idle pattern: nothing asserted
    apply(4'hF, 4'hF, 1'b0);
    chk(carry_out === 3'b000 && grp_gen_n === 1'b1 && grp_prop_n === 1'b1, "R1",
        32'({carry_out, grp_gen_n, grp_prop_n}), 32'b00011);
    // Exhaustive sweep over all nine inputs
    for (int v = 0; v < 512; v++) check_all(v[3:0], v[7:4], v[8]);
    // Seeded random revisit
    for (int r = 0; r < 200; r++) begin
      logic [8:0] v;
      v = 9'($urandom);
      check_all(v[3:0], v[7:4], v[8]);
    end
    // No memory: opposite pattern, then the idle pattern again
    apply(4'h0, 4'h0, 1'b1);
    apply(4'hF, 4'hF, 1'b0);
    chk(carry_out === 3'b000 && grp_gen_n === 1'b1 && grp_prop_n === 1'b1, "R7",
        32'({carry_out, grp_gen_n, grp_prop_n}), 32'b00011);
    // 16-bit adder built from four slices
    add16(16'hFFFF, 16'h0000, 1'b1);
    add16(16'hFFFF, 16'hFFFF, 1'b1);
    add16(16'h0000, 16'h0000, 1'b0);
    add16(16'h8000, 16'h8000, 1'b0);
    add16(16'h0FFF, 16'h0001, 1'b0);
    add16(16'h7FFF, 16'h0000, 1'b1);
    for (int r = 0; r < 300; r++) add16(16'($urandom), 16'($urandom), 1'($urandom));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule